// File: doc/BRIEF.md
# Header-Framed Serial Test Packet Receiver

This block sits at the far end of a serial test link. It takes a bit stream that has already been sampled, one bit for each strobe of a recovered bit clock, with a logic 1 as a high level and a logic 0 as a low level. While idle it slides a four-bit window over the stream, looking for the framing pattern 1, 0, 1, 0. Once it finds that pattern it takes the next four bits as a test nibble. The link carries at most 115.2 kbit/s, so strobes are far apart compared with the system clock.

With the nibble in hand, the block drives a device under test, which is a positive-edge D flip-flop. It presents the lowest data bit on the flip-flop's data pin and gives one clock pulse that lasts a single system cycle. One cycle after the pulse ends it samples the flip-flop's output. It then sends a reply back out at one bit per incoming strobe: the framing pattern first, then the three upper data bits, then the sampled output. When the last reply bit has gone out, the block returns to searching for a header with an empty window.

Top module: `pkt_rx_dut`

## Requirements
- R1: A synchronous reset, held over at least one rising edge, forces `dut_clk`, `reply_vld` and `reply_bit` low and leaves the block searching for a header with an all-zero window.
- R2: Only a cycle with `bit_vld` high carries a link bit. The value of `bit_in` in any other cycle has no effect on the outputs.
- R3: A header is recognised when the four most recent strobed bits, oldest first, read 1, 0, 1, 0. The window slides one bit per strobe, so leading bits that are not part of the pattern, or a partial pattern, do not prevent a match.
- R4: The four strobed bits after a header are captured most significant first (D3, D2, D1, D0). `dut_d` shows the lowest captured bit from the cycle after the fourth data strobe, and it stays stable across the DUT clock edge.
- R5: The cycle after the fourth data strobe is registered, `dut_clk` goes high for exactly one system cycle. In other words, it is high in the second cycle after the strobe cycle.
- R6: `dut_q` is sampled in the cycle after `dut_clk` returns low, and that sample forms the last reply bit.
- R7: The reply is eight bits, one per strobe after sampling, in the order 1, 0, 1, 0, D3, D2, D1, Q. Each bit appears on `reply_bit` with `reply_vld` high for the single cycle after its strobe.
- R8: Strobed bits that arrive during data capture, DUT exercise or the reply are never searched for a header. After the reply, the window restarts from zero, so a complete new header is needed.

Top module ports below are listed in port-list order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_vld | input | 1 | Strobe marking a sampled link bit |
| bit_in | input | 1 | Sampled link bit, NRZ level |
| dut_d | output | 1 | Data drive to the flip-flop under test |
| dut_clk | output | 1 | Clock drive to the flip-flop under test |
| dut_q | input | 1 | Output of the flip-flop under test |
| reply_vld | output | 1 | Reply bit strobe |
| reply_bit | output | 1 | Serial reply bit |

## Verification
Every output is registered, so each result appears in the cycle after the rising edge that causes it. The DUT pulse follows two edges after the fourth data strobe, the output sample follows one edge after the pulse falls, and each reply bit follows one edge after its strobe. The bench applies stimulus on falling edges and updates a behavioural model on rising edges. It compares every output at the next falling edge, which is the first stable point after each result becomes due. Strobes are spaced four cycles apart so that the three-cycle DUT exercise always finishes before the first reply strobe. Whole reply words are also checked against hand-computed values.

// File: rtl/pkt_rx_pkg.sv
package pkt_rx_pkg;
  typedef enum logic [2:0] {
    ST_HUNT,
    ST_DATA,
    ST_DRIVE,
    ST_PULSE,
    ST_SAMPLE,
    ST_SEND
  } st_e;
endpackage

// File: rtl/hdr_finder.sv
module hdr_finder #(
  parameter int W = 4,
  parameter logic [W-1:0] PAT = 4'b1010
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic shift_en,
  input  logic bit_in,
  output logic hit
);
  logic [W-1:0] win;

  function automatic logic [W-1:0] slide(input logic [W-1:0] w, input logic b);
    return {w[W-2:0], b};
  endfunction

  assign hit = shift_en && (slide(win, bit_in) == PAT);

  always_ff @(posedge clk) begin
    if (rst || clr) win <= '0;
    else if (shift_en) win <= slide(win, bit_in);
  end
endmodule

// File: rtl/nib_capture.sv
module nib_capture #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         shift_en,
  input  logic         bit_in,
  output logic [W-1:0] data,
  output logic         done
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  logic [CW-1:0] cnt;

  assign done = shift_en && (cnt == CW'(W - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      data <= '0;
    end else begin
      if (start) cnt <= '0;
      else if (shift_en) cnt <= cnt + 1'b1;
      if (shift_en) data <= {data[W-2:0], bit_in};
    end
  end
endmodule

// File: rtl/reply_ser.sv
module reply_ser #(
  parameter int HW = 4,
  parameter int DW = 4,
  parameter logic [HW-1:0] PAT = 4'b1010
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] payload,
  input  logic          shift_en,
  output logic          bit_o,
  output logic          vld_o,
  output logic          last
);
  localparam int N  = HW + DW;
  localparam int IW = $clog2(N);
  logic [N-1:0]  sr;
  logic [IW-1:0] idx;

  assign last = shift_en && (idx == IW'(N - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      sr    <= '0;
      idx   <= '0;
      bit_o <= 1'b0;
      vld_o <= 1'b0;
    end else begin
      vld_o <= 1'b0;
      if (load) begin
        sr  <= {PAT, payload};
        idx <= '0;
      end else if (shift_en) begin
        bit_o <= sr[N-1];
        vld_o <= 1'b1;
        sr    <= {sr[N-2:0], 1'b0};
        idx   <= idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pkt_rx_dut.sv
module pkt_rx_dut #(
  parameter int HDR_W = 4,
  parameter logic [HDR_W-1:0] HDR_PAT = 4'b1010,
  parameter int DATA_W = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_vld,
  input  logic bit_in,
  output logic dut_d,
  output logic dut_clk,
  input  logic dut_q,
  output logic reply_vld,
  output logic reply_bit
);
  import pkt_rx_pkg::*;

  st_e st;
  logic hdr_hit, data_done, in_hunt, rply_last, dclk_q;
  logic scan_en, cap_en, send_en, load_rply;
  logic [DATA_W-1:0] cap;

  function automatic logic [DATA_W-1:0] reply_payload(input logic [DATA_W-1:0] c,
                                                      input logic q);
    return {c[DATA_W-1:1], q};
  endfunction

  assign in_hunt   = (st == ST_HUNT);
  assign scan_en   = bit_vld && in_hunt;
  assign cap_en    = bit_vld && (st == ST_DATA);
  assign send_en   = bit_vld && (st == ST_SEND);
  assign load_rply = (st == ST_SAMPLE);

  hdr_finder #(.W(HDR_W), .PAT(HDR_PAT)) u_find (
    .clk(clk), .rst(rst), .clr(rply_last), .shift_en(scan_en),
    .bit_in(bit_in), .hit(hdr_hit)
  );

  nib_capture #(.W(DATA_W)) u_cap (
    .clk(clk), .rst(rst), .start(hdr_hit), .shift_en(cap_en),
    .bit_in(bit_in), .data(cap), .done(data_done)
  );

  reply_ser #(.HW(HDR_W), .DW(DATA_W), .PAT(HDR_PAT)) u_ser (
    .clk(clk), .rst(rst), .load(load_rply),
    .payload(reply_payload(cap, dut_q)), .shift_en(send_en),
    .bit_o(reply_bit), .vld_o(reply_vld), .last(rply_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_HUNT;
      dclk_q <= 1'b0;
    end else begin
      case (st)
        ST_HUNT:   if (hdr_hit) st <= ST_DATA;
        ST_DATA:   if (data_done) st <= ST_DRIVE;
        ST_DRIVE:  begin dclk_q <= 1'b1; st <= ST_PULSE; end
        ST_PULSE:  begin dclk_q <= 1'b0; st <= ST_SAMPLE; end
        ST_SAMPLE: st <= ST_SEND;
        ST_SEND:   if (rply_last) st <= ST_HUNT;
        default:   st <= ST_HUNT;
      endcase
    end
  end

  assign dut_d   = cap[0];
  assign dut_clk = dclk_q;
endmodule

// File: rtl/pkt_rx_chk.sv
module pkt_rx_chk (
  input logic clk,
  input logic rst,
  input logic bit_vld,
  input logic dut_clk,
  input logic dut_d,
  input logic reply_vld,
  input logic hdr_hit,
  input logic data_done,
  input logic in_hunt,
  input logic rply_last
);
  AST_RST_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!dut_clk && !reply_vld)); // R1
  AST_HIT_LEAVES_HUNT: assert property (@(posedge clk) disable iff (rst)
    hdr_hit |=> !in_hunt); // R3
  AST_D_HELD: assert property (@(posedge clk) disable iff (rst)
    $rose(dut_clk) |-> $stable(dut_d)); // R4
  AST_PULSE_AFTER_DATA: assert property (@(posedge clk) disable iff (rst)
    $rose(dut_clk) |-> $past(data_done, 2)); // R5
  AST_PULSE_ONE: assert property (@(posedge clk) disable iff (rst)
    dut_clk |=> !dut_clk); // R5
  AST_RPLY_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
    reply_vld |-> $past(bit_vld)); // R7
  AST_LAST_TO_HUNT: assert property (@(posedge clk) disable iff (rst)
    rply_last |=> in_hunt); // R8
endmodule

bind pkt_rx_dut pkt_rx_chk u_chk (
  .clk(clk), .rst(rst), .bit_vld(bit_vld), .dut_clk(dut_clk), .dut_d(dut_d),
  .reply_vld(reply_vld), .hdr_hit(hdr_hit), .data_done(data_done),
  .in_hunt(in_hunt), .rply_last(rply_last)
);

// File: tb/sim_pkt_rx_dut.sv
module sim_pkt_rx_dut;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_vld = 1'b0;
  logic bit_in = 1'b0;
  logic dut_q_r = 1'b0;
  logic dut_d, dut_clk, reply_vld, reply_bit;
  int vecs = 0, errs = 0, cyc = 0;
  int junk = 0;

  always #2 clk = ~clk;

  pkt_rx_dut u0 (
    .clk(clk), .rst(rst), .bit_vld(bit_vld), .bit_in(bit_in),
    .dut_d(dut_d), .dut_clk(dut_clk), .dut_q(dut_q_r),
    .reply_vld(reply_vld), .reply_bit(reply_bit)
  );

  // flip-flop under test
  always @(posedge dut_clk) dut_q_r <= dut_d;

  // behavioural reference model
  int m_mode = 0, m_win = 0, m_cnt = 0, m_nib = 0, m_q = 0;
  logic e_clk = 0, e_vld = 0, e_bit = 0;
  int m_out[$];

  always @(posedge clk) begin
    if (rst) begin
      m_mode = 0; m_win = 0; m_cnt = 0; m_nib = 0;
      e_clk = 0; e_vld = 0; e_bit = 0; m_out.delete();
    end else begin
      e_vld = 0;
      case (m_mode)
        0: if (bit_vld) begin
             m_win = ((m_win << 1) | int'(bit_in)) & 15;
             if (m_win == 10) begin m_mode = 1; m_cnt = 0; end
           end
        1: if (bit_vld) begin
             m_nib = ((m_nib << 1) | int'(bit_in)) & 15;
             m_cnt++;
             if (m_cnt == 4) m_mode = 2;
           end
        2: begin e_clk = 1; m_q = m_nib & 1; m_mode = 3; end
        3: begin e_clk = 0; m_mode = 4; end
        4: begin
             m_out = {1, 0, 1, 0, (m_nib >> 3) & 1, (m_nib >> 2) & 1,
                      (m_nib >> 1) & 1, m_q};
             m_mode = 5;
           end
        default: if (bit_vld) begin
             e_bit = m_out.pop_front() != 0;
             e_vld = 1;
             if (m_out.size() == 0) begin m_mode = 0; m_win = 0; end
           end
      endcase
    end
  end

  task automatic chk(string tag, logic act, logic exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s t=%0t actual=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  // per-cycle comparison and reply collection
  int rxq[$];
  always @(negedge clk) begin
    if (cyc > 0) begin
      if (rst) begin
        chk("R1 dut_clk", dut_clk, 1'b0);
        chk("R1 reply_vld", reply_vld, 1'b0);
        chk("R1 reply_bit", reply_bit, 1'b0);
      end else begin
        chk("R5 dut_clk", dut_clk, e_clk);
        chk("R4 dut_d", dut_d, m_nib[0]);
        chk("R7 reply_vld", reply_vld, e_vld);
        if (e_vld) chk("R7 reply_bit", reply_bit, e_bit);
        if (reply_vld) rxq.push_back(int'(reply_bit));
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errs++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  // one strobe then three idle cycles with noise on bit_in (R2)
  task automatic strobe(logic b);
    @(negedge clk); bit_vld = 1'b1; bit_in = b;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); bit_vld = 1'b0; junk++; bit_in = junk[0] ^ junk[2];
    end
  endtask

  task automatic send4(logic [3:0] v);
    for (int i = 3; i >= 0; i--) strobe(v[i]);
  endtask

  task automatic check_word(string tag, logic [7:0] exp);
    logic [7:0] got = '0;
    vecs++;
    if (rxq.size() != 8) begin
      errs++;
      $display("FAIL %s reply length actual=%0d expected=8", tag, rxq.size());
    end else begin
      for (int i = 0; i < 8; i++) got[7-i] = rxq[i] != 0;
      if (got !== exp) begin
        errs++;
        $display("FAIL %s reply actual=%b expected=%b", tag, got, exp);
      end
    end
    rxq.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R3 R4 R7: plain packet, reply strobes carry header-like bits (R8)
    send4(4'b1010); send4(4'b1101);
    send4(4'b1010); send4(4'b1010);
    check_word("R7", 8'b1010_110_1);
    // R8: only two bits after reply would complete a stale window
    strobe(1); strobe(0); strobe(0); strobe(0);
    vecs++;
    if (rxq.size() != 0 || dut_clk !== 1'b0) begin
      errs++; $display("FAIL R8 spurious packet actual=%0d expected=0", rxq.size());
    end
    // R2 R6: data with D0 = 0, noise between strobes
    send4(4'b1010); send4(4'b0110);
    repeat (8) strobe(1);
    check_word("R6", 8'b1010_011_0);
    // R3: sliding match after leading 1
    strobe(1); send4(4'b1010); send4(4'b0001);
    repeat (8) strobe(0);
    check_word("R3", 8'b1010_000_1);
    // R3: partial pattern 0101 then 0 completes a header
    strobe(0); send4(4'b0101); strobe(0); send4(4'b1010);
    repeat (8) strobe(1);
    check_word("R4", 8'b1010_101_0);
    // R1: reset mid-packet discards progress
    send4(4'b1010); strobe(1);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    send4(4'b0111); repeat (4) strobe(0);
    vecs++;
    if (rxq.size() != 0) begin
      errs++; $display("FAIL R1 reply after reset actual=%0d expected=0", rxq.size());
    end
    send4(4'b1010); send4(4'b1111); repeat (8) strobe(0);
    check_word("R7", 8'b1010_111_1);
    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule